// File: doc/BRIEF.md
# Occurrence-Recording Input Stage

This block is the front end of a sorter that uses no comparators. It takes unsigned integers of width `VAL_W`, one per clock, and files each into a storage slot chosen by the value itself. There is one slot for every possible value, so `N = 2**VAL_W` slots in all. Each slot holds a copy of the value it last received and a tally of how many times that value has arrived. The arriving value is decoded to a one-hot select. That select both enables the target slot and routes that slot's tally through one adder that all slots share.

A one-cycle `clr` pulse zeroes every tally and opens an intake window. The window lasts exactly `N` clocks, however many valid elements the set really holds. When the window closes, `win_done` pulses for one cycle. A later scanning stage then walks the slots through a read port. The read port takes a registered index and presents the chosen slot's value and tally.

Top module: `occ_recorder`

## Requirements
- R1: While `rst_n` is low and after it rises, every slot reads value 0 and tally 0, and `win_open` and `win_done` are 0.
- R2: A `clr` sampled at a clock edge makes `win_open` 1 for exactly the `N` cycles after that edge. `win_done` is 1 in the single cycle after the last of them. A `clr` inside an open window restarts the full `N`-cycle window.
- R3: A write is accepted at an edge where `wr_en` is 1, `win_open` is 1 and `clr` is 0. An accepted write of value v raises slot v's tally by exactly one and stores v in slot v's value register.
- R4: Repeated values accumulate. A tally is `VAL_W+1` bits wide, so `N` writes of one value leave a tally of exactly `N` without wrapping.
- R5: An accepted write changes only the slot its value addresses. At most one slot is selected per cycle.
- R6: A `clr` zeroes every tally at the next edge and leaves value registers unchanged. A write presented in the same cycle as `clr` is discarded.
- R7: When `wr_en` is 0, or the window is closed, no slot changes.
- R8: `rd_idx` is captured at each edge. `rd_val` and `rd_cnt` show the slot named by the captured index, so a new index is seen one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | One-cycle pulse: zero tallies and open the window |
| wr_en | input | 1 | Element valid this cycle |
| wr_val | input | VAL_W | Incoming element |
| rd_idx | input | VAL_W | Slot to read, registered inside |
| rd_val | output | VAL_W | Value register of the selected slot |
| rd_cnt | output | VAL_W+1 | Tally of the selected slot |
| win_open | output | 1 | Intake window is open |
| win_done | output | 1 | One-cycle pulse after the window closes |

## Verification
The bench drives a full window of `N` copies of the top value. A tally only `VAL_W` bits wide would wrap here and read 0 instead of `N`. It sends a write in the same cycle as a mid-window `clr`; a design that gave the write priority would leave a tally of one in the restarted set. It also writes after the window has closed and with `wr_en` low. A window counter that is off by one, or an enable that ignores the window, shows up as extra tallies or a `win_done` pulse one cycle early or late. It changes `rd_idx` and samples before the next edge. A combinational read path would already show the new slot there instead of the old one.

// File: rtl/occ_rec_pkg.sv
package occ_rec_pkg;
  // number of slots for a value width
  function automatic int unsigned slot_count(input int unsigned val_w);
    return 32'd1 << val_w;
  endfunction

  // tally width: one extra bit so a full window of one value fits
  function automatic int unsigned tally_width(input int unsigned val_w);
    return val_w + 1;
  endfunction
endpackage

// File: rtl/osr_onehot.sv
module osr_onehot #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned NSLOT = 16
) (
  input  logic [VAL_W-1:0] idx,
  input  logic             en,
  output logic [NSLOT-1:0] sel
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_dec
    localparam logic [VAL_W-1:0] MATCH = VAL_W'(i);
    assign sel[i] = en && (idx == MATCH);
  end
endmodule

// File: rtl/osr_shared_inc.sv
module osr_shared_inc #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CW    = 5
) (
  input  logic [NSLOT-1:0]         sel,
  input  logic [NSLOT-1:0][CW-1:0] cnt_arr,
  output logic [CW-1:0]            picked,
  output logic [CW-1:0]            bumped
);
  function automatic logic [CW-1:0] plus_one(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  always_comb begin
    picked = '0;
    for (int i = 0; i < NSLOT; i++) begin
      picked = picked | (cnt_arr[i] & {CW{sel[i]}});
    end
  end

  assign bumped = plus_one(picked);
endmodule

// File: rtl/osr_slot.sv
module osr_slot #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [VAL_W-1:0] din,
  input  logic [CW-1:0]    nxt_cnt,
  output logic [VAL_W-1:0] val_q,
  output logic [CW-1:0]    cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      val_q <= din;
      cnt_q <= nxt_cnt;
    end
  end
endmodule

// File: rtl/osr_window.sv
module osr_window #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CW    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic open_q,
  output logic done_q
);
  localparam logic [CW-1:0] LAST = CW'(NSLOT - 1);

  logic [CW-1:0] elapsed;
  logic          at_last;

  assign at_last = open_q && (elapsed == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      open_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (clr) begin
      elapsed <= '0;
      open_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= at_last;
      if (open_q) begin
        elapsed <= elapsed + CW'(1);
        if (at_last) open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/occ_recorder.sv
module occ_recorder
  import occ_rec_pkg::*;
#(
  parameter int unsigned VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [VAL_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_val,
  output logic [VAL_W:0]   rd_cnt,
  output logic             win_open,
  output logic             win_done
);
  localparam int unsigned NSLOT = slot_count(VAL_W);
  localparam int unsigned CW    = tally_width(VAL_W);

  logic                         wr_fire;
  logic [NSLOT-1:0]             sel_oh;
  logic [NSLOT-1:0][CW-1:0]     cnt_arr;
  logic [NSLOT-1:0][VAL_W-1:0]  val_arr;
  logic [CW-1:0]                inc_in;
  logic [CW-1:0]                inc_out;
  logic [VAL_W-1:0]             rd_idx_q;

  // write accepted only inside the window; clear wins over a write
  assign wr_fire = wr_en && win_open && !clr;

  osr_window #(.NSLOT(NSLOT), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .open_q(win_open), .done_q(win_done)
  );

  osr_onehot #(.VAL_W(VAL_W), .NSLOT(NSLOT)) u_dec (
    .idx(wr_val), .en(wr_fire), .sel(sel_oh)
  );

  osr_shared_inc #(.NSLOT(NSLOT), .CW(CW)) u_inc (
    .sel(sel_oh), .cnt_arr(cnt_arr), .picked(inc_in), .bumped(inc_out)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    osr_slot #(.VAL_W(VAL_W), .CW(CW)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .load(sel_oh[i]), .din(wr_val), .nxt_cnt(inc_out),
      .val_q(val_arr[i]), .cnt_q(cnt_arr[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_idx_q <= '0;
    else        rd_idx_q <= rd_idx;
  end

  assign rd_val = val_arr[rd_idx_q];
  assign rd_cnt = cnt_arr[rd_idx_q];
endmodule

// File: rtl/occ_recorder_chk.sv
module occ_recorder_chk #(
  parameter int unsigned VAL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [VAL_W-1:0] wr_val,
  input logic             wr_fire,
  input logic [(1<<VAL_W)-1:0] sel_oh,
  input logic [VAL_W-1:0] rd_idx_q,
  input logic [VAL_W-1:0] rd_val,
  input logic [VAL_W:0]   rd_cnt,
  input logic             win_open,
  input logic             win_done
);
  localparam int unsigned NSLOT = 1 << VAL_W;

  logic started;
  int unsigned open_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started  <= 1'b0;
      open_len <= 0;
    end else begin
      started <= 1'b1;
      if (clr)           open_len <= 0;
      else if (win_open) open_len <= open_len + 1;
    end
  end

  // R2: window closes after exactly NSLOT open cycles
  p_window_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (open_len == NSLOT) && !win_open);

  // R2: closing always raises done
  p_close_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $fell(win_open)) |-> win_done);

  // R5: exactly one slot selected on a write, none otherwise
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire ? ($countones(sel_oh) == 1) : (sel_oh == '0));

  // R4: a tally never exceeds the window length
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= (VAL_W+1)'(NSLOT));

  // R6: after a clear every tally reads zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(clr)) |-> (rd_cnt == '0));

  // R3: a write to the watched slot bumps its tally by one
  p_inc_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(wr_fire) && !$past(clr) && $stable(rd_idx_q)
     && ($past(wr_val) == rd_idx_q))
    |-> (rd_cnt == $past(rd_cnt) + 1'b1) && (rd_val == rd_idx_q));

  // R7: no write and no clear leaves the watched slot untouched
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(wr_fire) && !$past(clr) && $stable(rd_idx_q))
    |-> $stable(rd_cnt) && $stable(rd_val));
endmodule

bind occ_recorder occ_recorder_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_val(wr_val),
  .wr_fire(wr_fire), .sel_oh(sel_oh), .rd_idx_q(rd_idx_q),
  .rd_val(rd_val), .rd_cnt(rd_cnt),
  .win_open(win_open), .win_done(win_done)
);

// File: tb/tb_occ_recorder.sv
`timescale 1ns/1ps
module tb_occ_recorder;
  localparam int K = 4;
  localparam int N = 1 << K;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         wr_en = 1'b0;
  logic [K-1:0] wr_val = '0;
  logic [K-1:0] rd_idx = '0;
  logic [K-1:0] rd_val;
  logic [K:0]   rd_cnt;
  logic         win_open;
  logic         win_done;

  int total = 0;
  int bad = 0;
  int exp_cnt [N];
  int exp_val [N];
  int left = 0;
  bit exp_done = 0;

  always #10 clk = ~clk;

  occ_recorder #(.VAL_W(K)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_val(wr_val),
    .rd_idx(rd_idx), .rd_val(rd_val), .rd_cnt(rd_cnt),
    .win_open(win_open), .win_done(win_done)
  );

  function automatic int model_val(input int slot);
    return exp_val[slot];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_window();
    check(win_open == (left > 0), "R2 win_open", int'(win_open), int'(left > 0));
    check(win_done == exp_done, "R2 win_done", int'(win_done), int'(exp_done));
  endtask

  // clear pulse, optionally with a write that must be discarded (R6)
  task automatic start_set(input bit en, input logic [K-1:0] v);
    @(negedge clk);
    check_window();
    clr = 1'b1; wr_en = en; wr_val = v;
    for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    left = N;
    exp_done = 0;
  endtask

  task automatic feed(input bit en, input logic [K-1:0] v);
    @(negedge clk);
    clr = 1'b0;
    check_window();
    exp_done = 0;
    wr_en = en; wr_val = v;
    if (left > 0) begin
      if (en) begin
        exp_cnt[v]++;
        exp_val[v] = int'(v);
      end
      left--;
      if (left == 0) exp_done = 1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    check_window();
    exp_done = 0;
    if (left > 0) begin
      left--;
      if (left == 0) exp_done = 1;
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      clr = 1'b0; wr_en = 1'b0;
      rd_idx = K'(i);
      exp_done = 0;
      if (left > 0) begin
        left--;
        if (left == 0) exp_done = 1;
      end
      @(negedge clk);
      check(int'(rd_cnt) == exp_cnt[i], {req, " tally"}, int'(rd_cnt), exp_cnt[i]);
      check(int'(rd_val) == model_val(i), {req, " value"}, int'(rd_val), model_val(i));
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < N; i++) begin exp_cnt[i] = 0; exp_val[i] = 0; end
    repeat (3) @(negedge clk);
    check(win_open == 1'b0 && win_done == 1'b0, "R1 flags in reset",
          int'(win_open) + int'(win_done), 0);
    rst_n = 1'b1;
    check_all("R1");

    // random full set
    start_set(1'b0, '0);
    for (int j = 0; j < N; j++) feed(1'b1, K'($urandom_range(N-1)));
    idle(); idle();
    check_all("R3 R5");

    // one value N times
    start_set(1'b0, '0);
    for (int j = 0; j < N; j++) feed(1'b1, K'(N-1));
    idle();
    check_all("R4");

    // sparse valid, then writes after close
    start_set(1'b0, '0);
    for (int j = 0; j < N; j++) feed(bit'($urandom_range(1)), K'($urandom_range(N-1)));
    for (int j = 0; j < 3; j++) feed(1'b1, K'(j));
    idle();
    check_all("R7");

    // restart mid-window with a write on the clear cycle
    start_set(1'b0, '0);
    for (int j = 0; j < 5; j++) feed(1'b1, K'(j + 2));
    start_set(1'b1, K'(3));
    for (int j = 0; j < N; j++) feed(1'b1, K'($urandom_range(N-1) | 1));
    idle();
    check_all("R6 R2");

    // read port latency: show old slot until the next edge
    start_set(1'b0, '0);
    for (int j = 0; j < N; j++) feed(1'b1, (j < 4) ? K'(5) : K'(9));
    idle();
    @(negedge clk); rd_idx = K'(5);
    @(negedge clk);
    check(int'(rd_cnt) == 4, "R8 selected", int'(rd_cnt), 4);
    rd_idx = K'(9);
    #2;
    check(int'(rd_cnt) == 4, "R8 before edge", int'(rd_cnt), 4);
    @(negedge clk);
    check(int'(rd_cnt) == N - 4, "R8 after edge", int'(rd_cnt), N - 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule